// File: doc/BRIEF.md
# Bit-Serial Averaging Measurement Filter

This block smooths the sampled controlled variable before a controller takes its derivative. On each start pulse it takes the new 16-bit two's-complement sample (8 integer bits, 8 fraction bits). It then forms the mean of that sample and its own previously produced output. The arithmetic is bit-serial. A single full adder and two shift registers walk through the operands least significant bit first. A small binary counter paces the walk, and one extra step folds the carry back in and halves the sum.

A sequencing controller pulses `start` once per sampling period and waits for `done`. The result is on `filtOut` from the `done` cycle until the next accepted start. An operator-controlled `bypass` input turns the smoothing off. In that case the result is the raw sample, but the step still takes the same number of clocks, so the controller's sequencing does not change. `bypass` is captured together with the sample when a start is accepted.

Top module: `serial_avg_filter`

## Requirements
- R1: While reset is low, and on the first cycle after it, `filtOut` is 0x0000 and `done` is 0.
- R2: With `bypass` low at the accepting edge, the result equals floor((P + Y) / 2). Here P is the previous `filtOut` and Y is the sample, both read as signed 16-bit values. This is the low 16 bits of the 17-bit signed sum shifted right by one with the sign kept.
- R3: The average never wraps. 0x7FFF with 0x7FFF gives 0x7FFF, 0x8000 with 0x8000 gives 0x8000, 0x7FFF with 0x8000 gives 0xFFFF, and 0x0000 with 0xFFFF gives 0xFFFF, so rounding is toward minus infinity.
- R4: With `bypass` high at the accepting edge, the result equals the sample, and the previous output has no effect.
- R5: A start is accepted on a rising clock edge where `start` is high and no step is in progress. `done` is then high for exactly one cycle, beginning 17 clock edges after the accepting edge.
- R6: When no step is in progress and no start is given, `filtOut` does not change.
- R7: A `start` pulse during a step in progress is ignored, including one on the step's final edge. Neither the result nor the `done` timing changes.
- R8: A start given in the same cycle that `done` is high is accepted. It uses the value just produced as its previous output.
- R9: `sample` and `bypass` are used only at the accepting edge. Changes to either during a step have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new filter step |
| bypass | input | 1 | High: pass the sample through unfiltered |
| sample | input | 16 | New Q8.8 two's-complement measurement |
| done | output | 1 | One-cycle pulse when the result is ready |
| filtOut | output | 16 | Q8.8 filtered value, valid from `done` until the next accepted start |

## Verification
Two events can meet on the same edge: the completion of a step and the acceptance of the next start. The bench provokes this by raising `start` in the very cycle it sees `done`. It also provokes a start arriving on the final shifting edge, one cycle too early, which must be ignored. In the back-to-back case it checks that the new result uses the value that had just been produced as its previous output. In the early case it checks that `done` still arrives exactly 17 edges after the original start and that the result does not change. A lengthy arithmetic sweep with mixed idle gaps, bypass steps and input changes during a step judges both cases against a reference model kept in the bench.

// File: rtl/serial_avg_pkg.sv
package serial_avg_pkg;
  // Strobes from sequencing control to the serial datapath
  typedef struct packed {
    logic load;    // capture operands, clear carry
    logic shift;   // advance one bit position
    logic extend;  // final step: use held sign in place of the accumulator bit
  } avgStrobe_t;
endpackage

// File: rtl/serial_avg_ctrl.sv
module serial_avg_ctrl
  import serial_avg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output avgStrobe_t strobe,
  output logic       done
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic             busy;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (stepCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load   = start && !busy;
    strobe.shift  = busy;
    strobe.extend = busy && (stepCnt == LAST);
  end
endmodule

// File: rtl/serial_avg_dp.sv
module serial_avg_dp
  import serial_avg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  avgStrobe_t        strobe,
  input  logic              bypass,
  input  logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] filtOut
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] accReg;   // previous value in, result out (rotates)
  logic [DATA_W-1:0] smpReg;   // sample, arithmetic shift right
  logic              carryReg;
  logic              accSign;
  logic              opA, opB, sumBit, carryNext;

  // one-bit full adder
  always_comb begin
    opA       = strobe.extend ? accSign : accReg[0];
    opB       = smpReg[0];
    sumBit    = opA ^ opB ^ carryReg;
    carryNext = (opA & opB) | (opA & carryReg) | (opB & carryReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= '0;
      smpReg   <= '0;
      carryReg <= 1'b0;
      accSign  <= 1'b0;
    end else if (strobe.load) begin
      // bypass: average the sample with itself, giving the sample exactly
      smpReg   <= sample;
      accReg   <= bypass ? sample : accReg;
      accSign  <= bypass ? sample[MSB] : accReg[MSB];
      carryReg <= 1'b0;
    end else if (strobe.shift) begin
      accReg   <= {sumBit, accReg[MSB:1]};
      smpReg   <= {smpReg[MSB], smpReg[MSB:1]};
      carryReg <= carryNext;
    end
  end

  assign filtOut = accReg;
endmodule

// File: rtl/serial_avg_filter.sv
module serial_avg_filter
  import serial_avg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              bypass,
  input  logic [DATA_W-1:0] sample,
  output logic              done,
  output logic [DATA_W-1:0] filtOut
);
  avgStrobe_t strobe;

  serial_avg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  serial_avg_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .bypass  (bypass),
    .sample  (sample),
    .filtOut (filtOut)
  );
endmodule

// File: rtl/serial_avg_chk.sv
module serial_avg_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              bypass,
  input logic [DATA_W-1:0] sample,
  input logic              done,
  input logic [DATA_W-1:0] filtOut
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic              ckBusy;
  logic [CNT_W-1:0]  ckCnt;
  logic [DATA_W-1:0] expVal;
  logic [DATA_W-1:0] smpLat;
  logic              bypLat;
  logic signed [DATA_W:0] sumWide;

  always_comb sumWide = $signed({filtOut[DATA_W-1], filtOut}) + $signed({sample[DATA_W-1], sample});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckBusy <= 1'b0;
      ckCnt  <= '0;
      expVal <= '0;
      smpLat <= '0;
      bypLat <= 1'b0;
    end else if (start && !ckBusy) begin
      ckBusy <= 1'b1;
      ckCnt  <= '0;
      smpLat <= sample;
      bypLat <= bypass;
      expVal <= bypass ? sample : sumWide[DATA_W:1];
    end else if (ckBusy) begin
      if (ckCnt == LAST) ckBusy <= 1'b0;
      else ckCnt <= ckCnt + 1'b1;
    end
  end

  // R5: done follows the 17th edge after acceptance, and only then
  p_done_on_time_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ckBusy && ckCnt == LAST) |=> done);
  p_no_stray_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(ckBusy && ckCnt == LAST) |=> !done);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2, R3, R7, R8, R9: result matches operands captured at acceptance
  p_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> filtOut == expVal);
  // R4: bypass gives the raw sample
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && bypLat) |-> filtOut == smpLat);
  // R6: output holds while idle
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ckBusy && !start) |=> $stable(filtOut));
endmodule

bind serial_avg_filter serial_avg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/serial_avg_filter_bench.sv
module serial_avg_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        bypass = 1'b0;
  logic [15:0] sample = '0;
  logic        done;
  logic [15:0] filtOut;

  int checks = 0;
  int fails  = 0;
  logic [15:0] refF = '0;

  always #10 clk = ~clk;  // 50 MHz

  serial_avg_filter #(.DATA_W(16)) u_serial_avg_filter (
    .clk(clk), .rstN(rstN), .start(start), .bypass(bypass),
    .sample(sample), .done(done), .filtOut(filtOut)
  );

  function automatic logic [15:0] avgRef(input logic [15:0] p, input logic [15:0] y);
    logic signed [16:0] s;
    s = $signed({p[15], p}) + $signed({y[15], y});
    return s[16:1];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; start is raised immediately.
  task automatic runStep(input logic [15:0] y, input logic byp, input int idleN,
                         input int glitchK, input bit bypFlip, input string tag);
    logic [15:0] exp;
    int k;
    exp = byp ? y : avgRef(refF, y);
    start = 1'b1; sample = y; bypass = byp; k = 0;
    while (1) begin
      @(negedge clk); k++;
      if (k == 1) begin
        start = 1'b0;
        sample = ~y;                 // R9: later sample must not matter
        if (bypFlip) bypass = ~byp;  // R9: later bypass must not matter
      end
      if (k == glitchK) start = 1'b1;       // R7: start while busy
      if (k == glitchK + 1) start = 1'b0;
      if (done || k > 40) break;
    end
    check(k == 18, (glitchK > 0) ? "R7 done timing" : "R5 done timing", k, 18);
    check(filtOut == exp, tag, filtOut, exp);
    refF = exp;
    bypass = byp;
    for (int i = 0; i < idleN; i++) begin
      @(negedge clk);
      if (i == 0) check(done == 1'b0, "R5 single pulse", done, 0);
      check(filtOut == exp, "R6 hold", filtOut, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    check(filtOut == 16'h0000, "R1 reset out", filtOut, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(filtOut == 16'h0000, "R1 after reset out", filtOut, 0);
    check(done == 1'b0, "R1 after reset done", done, 0);

    // R3 corners
    runStep(16'h7FFF, 1'b1, 1, 0, 1'b0, "R4 load max");
    runStep(16'h7FFF, 1'b0, 1, 0, 1'b0, "R3 max+max");
    runStep(16'h8000, 1'b1, 1, 0, 1'b0, "R4 load min");
    runStep(16'h8000, 1'b0, 1, 0, 1'b0, "R3 min+min");
    runStep(16'h7FFF, 1'b1, 1, 0, 1'b0, "R4 load max");
    runStep(16'h8000, 1'b0, 1, 0, 1'b0, "R3 max+min");
    runStep(16'h0000, 1'b1, 1, 0, 1'b0, "R4 load zero");
    runStep(16'hFFFF, 1'b0, 2, 0, 1'b0, "R3 floor negative");
    // R4: previous value ignored
    runStep(16'h1234, 1'b1, 1, 0, 1'b1, "R4 bypass with flip");
    // R7 glitch on final edge, then R8 back-to-back
    runStep(16'h0F00, 1'b0, 0, 17, 1'b0, "R7 final-edge start");
    runStep(16'hF100, 1'b0, 1, 0, 1'b0, "R8 back-to-back");

    lcg = 32'h1ACE5EED;
    for (int i = 0; i < 300; i++) begin
      logic byp;
      int idleN, gk;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      byp = (i % 7 == 3);
      idleN = i % 3;
      gk = (i % 5 == 1) ? 8 : ((i % 5 == 2) ? 17 : 0);
      runStep(lcg[23:8], byp, idleN, gk, (i % 4 == 0),
              byp ? "R4 sweep" : (idleN == 0 ? "R8 sweep" : "R2 sweep"));
    end
    @(negedge clk);
    check(filtOut == refF, "R6 final hold", filtOut, refF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule